// File: doc/BRIEF.md
# DMA Channel Interrupt Source Logic

This block raises the interrupt requests of a two-channel DMA controller whose channels each carry two sub-channels, A and B. A small control register holds, for every channel, run bits, interrupt-enable bits, a master enable, a break-interrupt enable and a bit that selects short or full address mode. From that register the block derives four independent request lines. It also derives a fixed-priority encoded vector, so that a simple interrupt controller can service the most urgent pending source.

A request is a level, not an event. It is high while a source's interrupt enable is set and the enable it watches is clear. In short address mode every source reports the end of transfer of its own sub-channel. In full address mode source xA reports the end of transfer of channel x, and source xB reports a transfer break on channel x. The transfer engine is not part of the block. It appears only as per-source completion pulses that clear the relevant enable bit. Software writes and reads the control register through a plain write port and a continuous readback.

Top module: `dmairq_top`

## Requirements
- R1: After reset every control bit is 0, all four request lines are 0 and `irq_valid` is 0.
- R2: Register layout: channel c uses bits [8c+7:8c]. Bit 0 is run A, bit 1 run B, bit 2 interrupt enable A, bit 3 interrupt enable B, bit 4 master enable, bit 5 break-interrupt enable and bit 6 full mode. Bit 7 is reserved and always reads 0. A write with `wr_en` high loads all other bits, and `rd_data` shows the new value after that clock edge.
- R3: Source index 2c is channel c's A source. It is high on the clock edge after the register holds interrupt enable A = 1 and run A = 0, in either mode. Otherwise it is low.
- R4: In short mode, source index 2c+1 is high on the edge after the register holds interrupt enable B = 1 and run B = 0.
- R5: In full mode, source index 2c+1 is high on the edge after the register holds break-interrupt enable = 1 and master enable = 0. Run B and interrupt enable B then have no effect on it.
- R6: `irq_valid` is 1 exactly when some request line is high. `irq_vec` then holds the lowest pending index. Priority from highest to lowest is 0 (channel 0 A), 1 (channel 0 B), 2 (channel 1 A), 3 (channel 1 B).
- R7: A pulse on `xfer_done[2c]` clears run A of channel c. A pulse on `xfer_done[2c+1]` clears run B in short mode and master enable in full mode. The mode used is the one the register will hold after that edge. A completion pulse overrides a write to the same bit in the same cycle.
- R8: A request caused by a completion pulse appears one edge after the pulse's edge. It drops one edge after software sets the watched enable again or clears the interrupt enable.
- R9: A setup write that creates an interrupt condition is not masked: the request rises on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| xfer_done | input | 4 | Completion pulse per source from the transfer engine |
| rd_data | output | 16 | Control register readback |
| irq | output | 4 | Request lines, index 2c = channel c A, 2c+1 = channel c B |
| irq_vec | output | 2 | Index of the highest-priority pending source |
| irq_valid | output | 1 | Some source is pending |

## Verification
On every cycle the assertions check four things: that a completion pulse clears the watched enable, that a plain write loads the register, that each source follows its mode-dependent condition one edge later, and that the vector always names a pending source with no higher-priority one set. Some behaviour only the bench's scenarios can show: the exact cycle a request rises after a completion, the effect of a mode switch on the B source, and precedence when a write and a completion collide. The same goes for the reset state and the unmasked setup case. The bench compares every output against a model computed in bench functions, under random writes and pulses as well as directed sequences.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    // Per-channel control fields, packed so that run_a lands in bit 0.
    typedef struct packed {
        logic full;    // bit 6: full address mode
        logic brk_ie;  // bit 5: break interrupt enable
        logic master;  // bit 4: master enable
        logic ie_b;    // bit 3
        logic ie_a;    // bit 2
        logic run_b;   // bit 1
        logic run_a;   // bit 0
    } chan_cfg_t;

    localparam int unsigned CHAN_W = 8;
    localparam int unsigned CFG_W  = $bits(chan_cfg_t);

endpackage

// File: rtl/dmairq_ctrl_reg.sv
module dmairq_ctrl_reg
    import dmairq_pkg::*;
#(
    parameter int unsigned NCH = 2,
    localparam int unsigned SRC  = 2 * NCH,
    localparam int unsigned REGW = NCH * CHAN_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REGW-1:0]           wr_data,
    input  logic [SRC-1:0]            xfer_done,
    output chan_cfg_t [NCH-1:0]       cfg_o
);

    typedef struct packed {
        chan_cfg_t [NCH-1:0] cfg;
    } reg_st_t;

    reg_st_t s_d, s_q;
    chan_cfg_t [NCH-1:0] wr_img;

    // Write image: drop the reserved top bit of each channel byte.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_img
            assign wr_img[c] = chan_cfg_t'(wr_data[c*CHAN_W +: CFG_W]);
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.cfg = wr_img;
        end
        for (int c = 0; c < NCH; c++) begin
            if (xfer_done[2*c]) begin
                s_d.cfg[c].run_a = 1'b0;
            end
            if (xfer_done[2*c+1]) begin
                if (s_d.cfg[c].full) begin
                    s_d.cfg[c].master = 1'b0;
                end else begin
                    s_d.cfg[c].run_b = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o = s_q.cfg;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            p_done_a_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
                xfer_done[2*c] |=> !cfg_o[c].run_a);
            p_done_b_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (xfer_done[2*c+1] && !s_d.cfg[c].full) |=> !cfg_o[c].run_b);
            p_done_b_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (xfer_done[2*c+1] && s_d.cfg[c].full) |=> !cfg_o[c].master);
        end
    endgenerate

    p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && xfer_done == '0) |=> (cfg_o == $past(wr_img)));

endmodule

// File: rtl/dmairq_src.sv
module dmairq_src
    import dmairq_pkg::*;
#(
    parameter int unsigned NCH = 2,
    localparam int unsigned SRC = 2 * NCH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  chan_cfg_t [NCH-1:0]  cfg_i,
    output logic [SRC-1:0]       irq_o
);

    typedef struct packed {
        logic [SRC-1:0] irq;
    } src_st_t;

    src_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int c = 0; c < NCH; c++) begin
            // A source: end of transfer in both modes
            s_d.irq[2*c] = cfg_i[c].ie_a && !cfg_i[c].run_a;
            // B source: meaning depends on address mode
            if (cfg_i[c].full) begin
                s_d.irq[2*c+1] = cfg_i[c].brk_ie && !cfg_i[c].master;
            end else begin
                s_d.irq[2*c+1] = cfg_i[c].ie_b && !cfg_i[c].run_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            p_end_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_i[c].ie_a && !cfg_i[c].run_a) |=> irq_o[2*c]);
            p_quiet_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg_i[c].ie_a |=> !irq_o[2*c]);
            p_end_b_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!cfg_i[c].full && cfg_i[c].ie_b && !cfg_i[c].run_b) |=> irq_o[2*c+1]);
            p_break_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_i[c].full && cfg_i[c].brk_ie && !cfg_i[c].master) |=> irq_o[2*c+1]);
            p_break_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_i[c].full && !cfg_i[c].brk_ie) |=> !irq_o[2*c+1]);
        end
    endgenerate

endmodule

// File: rtl/dmairq_prio.sv
module dmairq_prio #(
    parameter int unsigned SRC = 4,
    localparam int unsigned VECW = (SRC > 1) ? $clog2(SRC) : 1
) (
    input  logic [SRC-1:0]  irq_i,
    output logic [VECW-1:0] vec_o,
    output logic            valid_o
);

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        vec_o   = '0;
        valid_o = 1'b0;
        for (int i = SRC - 1; i >= 0; i--) begin
            if (irq_i[i]) begin
                vec_o   = VECW'(i);
                valid_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
    import dmairq_pkg::*;
#(
    parameter int unsigned NCH = 2,
    localparam int unsigned SRC  = 2 * NCH,
    localparam int unsigned REGW = NCH * CHAN_W,
    localparam int unsigned VECW = (SRC > 1) ? $clog2(SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REGW-1:0]  wr_data,
    input  logic [SRC-1:0]   xfer_done,
    output logic [REGW-1:0]  rd_data,
    output logic [SRC-1:0]   irq,
    output logic [VECW-1:0]  irq_vec,
    output logic             irq_valid
);

    chan_cfg_t [NCH-1:0] cfg;

    dmairq_ctrl_reg #(.NCH(NCH)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .xfer_done (xfer_done),
        .cfg_o     (cfg)
    );

    dmairq_src #(.NCH(NCH)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg),
        .irq_o (irq)
    );

    dmairq_prio #(.SRC(SRC)) u_prio (
        .irq_i   (irq),
        .vec_o   (irq_vec),
        .valid_o (irq_valid)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_rd
            assign rd_data[c*CHAN_W +: CHAN_W] = {{(CHAN_W-CFG_W){1'b0}}, cfg[c]};
        end
    endgenerate

    p_vec_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq[irq_vec]);
    p_vec_highest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((irq & ((SRC'(1) << irq_vec) - SRC'(1))) == '0));
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == '0) |-> !irq_valid);

endmodule

// File: tb/sim_dmairq_top.sv
module sim_dmairq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  xfer_done = '0;
    logic [15:0] rd_data;
    logic [3:0]  irq;
    logic [1:0]  irq_vec;
    logic        irq_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_reg = '0;
    logic [3:0]  m_irq = '0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    dmairq_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .xfer_done(xfer_done), .rd_data(rd_data), .irq(irq),
        .irq_vec(irq_vec), .irq_valid(irq_valid)
    );

    function automatic logic [15:0] next_reg(logic [15:0] r, logic w, logic [15:0] wd, logic [3:0] dn);
        logic [15:0] n = w ? (wd & 16'h7F7F) : r;
        for (int c = 0; c < 2; c++) begin
            if (dn[2*c]) n[8*c] = 1'b0;
            if (dn[2*c+1]) begin
                if (n[8*c+6]) n[8*c+4] = 1'b0;
                else          n[8*c+1] = 1'b0;
            end
        end
        return n;
    endfunction

    function automatic logic [3:0] cond(logic [15:0] r);
        logic [3:0] q;
        for (int c = 0; c < 2; c++) begin
            q[2*c] = r[8*c+2] & ~r[8*c];
            q[2*c+1] = r[8*c+6] ? (r[8*c+5] & ~r[8*c+4]) : (r[8*c+3] & ~r[8*c+1]);
        end
        return q;
    endfunction

    function automatic logic [2:0] prio(logic [3:0] q);
        for (int i = 0; i < 4; i++) if (q[i]) return {1'b1, 2'(i)};
        return 3'b000;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic step(logic w, logic [15:0] wd, logic [3:0] dn);
        logic [2:0] p;
        wr_en = w; wr_data = wd; xfer_done = dn;
        @(posedge clk);
        m_irq = cond(m_reg);
        m_reg = next_reg(m_reg, w, wd, dn);
        @(negedge clk);
        wr_en = 1'b0; xfer_done = '0;
        p = prio(m_irq);
        chk("R2 readback", rd_data, m_reg);
        chk("R3/R4/R5 irq", {12'd0, irq}, {12'd0, m_irq});
        chk("R6 vector", {13'd0, irq_valid, irq_vec}, {13'd0, p[2], p[2] ? p[1:0] : 2'b00});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] wd;
        logic [3:0]  dn;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset rd_data", rd_data, 16'h0000);
        chk("R1 reset irq", {12'd0, irq}, 16'h0000);
        chk("R1 reset valid", {15'd0, irq_valid}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reserved bits read 0
        step(1'b1, 16'hFFFF, 4'h0);
        chk("R2 reserved bits", rd_data & 16'h8080, 16'h0000);
        // R9: setup write with ie_a=1 run_a=0 on channel 0 raises 0A next edge
        step(1'b1, 16'h0004, 4'h0);
        step(1'b0, 16'h0000, 4'h0);
        chk("R9 unmasked setup", {12'd0, irq}, 16'h0001);
        // R8: re-enable run drops request
        step(1'b1, 16'h0005, 4'h0);
        step(1'b0, 16'h0000, 4'h0);
        chk("R8 drop on re-enable", {12'd0, irq}, 16'h0000);
        // R7/R8: completion clears run_a, request one edge later
        step(1'b0, 16'h0000, 4'b0001);
        chk("R7 run cleared", rd_data, 16'h0004);
        chk("R8 not yet", {12'd0, irq}, 16'h0000);
        step(1'b0, 16'h0000, 4'h0);
        chk("R8 raised", {12'd0, irq}, 16'h0001);
        // R5: full mode channel 1, break source ignores ie_b/run_b
        step(1'b1, 16'h7A00, 4'h0);  // full, brk_ie, master, ie_b, run_b=1
        step(1'b0, 16'h0000, 4'b1000);
        chk("R7 full clears master", rd_data, 16'h6A00);
        step(1'b0, 16'h0000, 4'h0);
        chk("R5 break raised", {12'd0, irq}, 16'h0008);
        step(1'b1, 16'h4800, 4'h0); // full, ie_b=1 run_b=0, no brk_ie
        step(1'b0, 16'h0000, 4'h0);
        chk("R5 ie_b ignored in full", {12'd0, irq}, 16'h0000);
        // R4: short mode channel 1 B
        step(1'b1, 16'h0800, 4'h0);
        step(1'b0, 16'h0000, 4'h0);
        chk("R4 short B", {12'd0, irq}, 16'h0008);
        // R6: priority with 0B and 1A pending
        step(1'b1, 16'h0408, 4'h0);
        step(1'b0, 16'h0000, 4'h0);
        chk("R6 vec 0B over 1A", {14'd0, irq_vec}, 16'h0001);
        // R7: completion beats same-cycle write
        step(1'b1, 16'h0001, 4'b0001);
        chk("R7 done over write", rd_data, 16'h0000);

        for (int i = 0; i < 3000; i++) begin
            wd = 16'($urandom());
            dn = (($urandom() % 4) == 0) ? 4'($urandom()) : 4'h0;
            step(($urandom() % 4) == 0, wd, dn);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule